// File: doc/BRIEF.md
# Dual-Tone Sample Generator

This block produces the digital code for one 8-bit DAC channel. It runs in one of two ways. In plain mode the code is the byte that software last wrote to the data register. In tone mode, two oscillators (a low-frequency group and a high-frequency group) each step a 32-entry, 5-bit sine table. The two table samples are added, and the 6-bit sum becomes the upper six bits of the code. The lowest two bits of the code still come from the data register.

Each oscillator counts down on every second clock. When its counter passes zero, it reloads from a software-written reload value and moves its table index on by one. Software can force either group's contribution to zero. While a group is forced to zero it is parked: its index returns to 0 and its counter follows the reload value. When it is released it therefore starts at a known phase.

A timer write can update the reload value alone, or the reload value and the live counter together. A per-group write-through bit selects which. Two state machines set the behaviour. Each oscillator has PARK and RUN states. The output stage has OFF, PLAIN and TONE states. The oscillator moves PARK→RUN when its zero-select bit clears and RUN→PARK when it is set. The output stage moves OFF→PLAIN or OFF→TONE when output is enabled (chosen by the mode bit), PLAIN↔TONE when the mode bit changes, and PLAIN/TONE→OFF when output is disabled.

Top module: `dtmf_sample_gen`

## Requirements
- R1: After reset, the outputs are `dac_code`=0x00 and `dac_valid`=0. The data register is 0x00. The control register holds output disabled, plain mode, and both groups forced to zero.
- R2: Register addresses are: 0 = control, 1 = data, 2 = low-group reload, 3 = high-group reload. Control bits are: bit0 output enable, bit1 tone mode, bit2 low-group zero, bit3 high-group zero, bit4 low-group write-through, bit5 high-group write-through. With output enable at 0, `dac_valid` is 0 and `dac_code` is 0 whatever the data register holds. This takes effect one cycle after the edge that writes the control register.
- R3: With output enabled and tone mode at 0, `dac_code` equals the data register and `dac_valid` is 1. A data write shows on the output right after its write edge.
- R4: With output enabled and tone mode at 1, `dac_code[7:2]` is the sum of the two group samples and `dac_code[1:0]` equals data register bits 1:0.
- R5: A group whose zero bit is 1 contributes 0. From the cycle after the control write edge, its index is held at 0 and its counter is held at the reload value.
- R6: Sample k of the sine table is, for k = 0..31: 16,19,21,24,26,28,30,31,31,31,30,28,26,24,21,19,15,12,10,7,5,3,1,0,0,0,1,3,5,7,10,12.
- R7: With reload value L, a released group outputs sample 0 for the first 2(L+1) cycles after its release cycle. It then advances one entry every 2(L+1) cycles and wraps from entry 31 to entry 0. The release cycle is the cycle after the control write edge.
- R8: While a group runs, a reload write with its write-through bit at 0 leaves the live counter alone, so the new value applies from the next reload. With the bit at 1, the counter takes the written value at the write edge.
- R9: The tone sum never exceeds 62, so it always fits the 6-bit field without wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| dac_code | output | 8 | Code for the DAC ladder |
| dac_valid | output | 1 | High when the output is enabled |

## Verification
The assertions assume that `wr_en` is driven cleanly on every cycle after reset and that writes use only the four defined addresses. They also assume that no reload write lands on the same edge that releases a group from PARK. The bench meets these conditions by changing inputs only between clock edges and by issuing one write per cycle. It writes reload values only while a group is parked, or several cycles after the group's release edge. Expected codes are derived from the sine table and the 2(L+1) stepping rule, counted from each release edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int TBL_DEPTH = 32;
    localparam int SMP_W     = 5;
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int SUM_W     = SMP_W + 1;
    localparam int MAX_SUM   = 2 * ((1 << SMP_W) - 1);
    localparam int N_GROUPS  = 2;

    localparam int ADR_CTL    = 0;
    localparam int ADR_DATA   = 1;
    localparam int ADR_TMR_LO = 2;

    typedef struct packed {
        logic hi_wthru;
        logic lo_wthru;
        logic hi_zero;
        logic lo_zero;
        logic tone_mode;
        logic out_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_RESET = 6'b001100;

    typedef enum logic {
        PATH_PARK,
        PATH_RUN
    } path_state_e;

    typedef enum logic [1:0] {
        OUT_OFF,
        OUT_PLAIN,
        OUT_TONE
    } out_state_e;

    function automatic logic [SMP_W-1:0] sine_at(input logic [IDX_W-1:0] k);
        logic [SMP_W-1:0] v;
        case (k)
            5'd0:  v = 5'd16;
            5'd1:  v = 5'd19;
            5'd2:  v = 5'd21;
            5'd3:  v = 5'd24;
            5'd4:  v = 5'd26;
            5'd5:  v = 5'd28;
            5'd6:  v = 5'd30;
            5'd7:  v = 5'd31;
            5'd8:  v = 5'd31;
            5'd9:  v = 5'd31;
            5'd10: v = 5'd30;
            5'd11: v = 5'd28;
            5'd12: v = 5'd26;
            5'd13: v = 5'd24;
            5'd14: v = 5'd21;
            5'd15: v = 5'd19;
            5'd16: v = 5'd15;
            5'd17: v = 5'd12;
            5'd18: v = 5'd10;
            5'd19: v = 5'd7;
            5'd20: v = 5'd5;
            5'd21: v = 5'd3;
            5'd22: v = 5'd1;
            5'd23: v = 5'd0;
            5'd24: v = 5'd0;
            5'd25: v = 5'd0;
            5'd26: v = 5'd1;
            5'd27: v = 5'd3;
            5'd28: v = 5'd5;
            5'd29: v = 5'd7;
            5'd30: v = 5'd10;
            default: v = 5'd12;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dtmf_regs.sv
module dtmf_regs
    import dtmf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] data_q,
    output logic [N_GROUPS-1:0] tmr_wr
);

    logic sel_ctl;
    logic sel_data;
    logic spare_bits_unused;

    assign sel_ctl  = wr_en && (wr_addr == ADDR_W'(ADR_CTL));
    assign sel_data = wr_en && (wr_addr == ADDR_W'(ADR_DATA));
    assign spare_bits_unused = ^wr_data[DATA_W-1:CTL_W];

    // Reload-value strobes, one per tone group at consecutive addresses
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_tmr_sel
        assign tmr_wr[g] = wr_en && (wr_addr == ADDR_W'(ADR_TMR_LO + g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            data_q <= '0;
        end else begin
            if (sel_ctl) begin
                ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
            end
            if (sel_data) begin
                data_q <= wr_data;
            end
        end
    end

    AST_CTL_TAKES: assert property (@(posedge clk) disable iff (!rst_n) sel_ctl |=> ctl_q == $past(wr_data[CTL_W-1:0])); // R2

endmodule

// File: rtl/dtmf_tone_path.sv
module dtmf_tone_path
    import dtmf_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    input  logic             tmr_wr,
    input  logic             wthru,
    input  logic [TMR_W-1:0] wr_val,
    output logic [SMP_W-1:0] sample
);

    path_state_e       st_q;
    path_state_e       st_d;
    logic [TMR_W-1:0]  latch_q;
    logic [TMR_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pre_q;
    logic              tick;
    logic              underflow;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PATH_PARK;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PATH_PARK: if (!park) st_d = PATH_RUN;
            PATH_RUN:  if (park)  st_d = PATH_PARK;
            default:   st_d = PATH_PARK;
        endcase
    end

    assign tick      = (st_q == PATH_RUN) && pre_q;
    assign underflow = tick && (cnt_q == '0);

    // Reload value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (tmr_wr) begin
            latch_q <= wr_val;
        end
    end

    // Divider phase, down-counter and table index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (st_q == PATH_PARK) begin
            pre_q <= 1'b0;
            cnt_q <= latch_q;
            idx_q <= '0;
        end else begin
            pre_q <= ~pre_q;
            if (tmr_wr && wthru) begin
                cnt_q <= wr_val;
            end else if (underflow) begin
                cnt_q <= latch_q;
            end else if (tick) begin
                cnt_q <= cnt_q - TMR_W'(1);
            end
            if (underflow) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Sample output
    always_comb begin
        unique case (st_q)
            PATH_RUN: sample = sine_at(idx_q);
            default:  sample = '0;
        endcase
    end

    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n) park |=> sample == '0); // R5
    AST_PARK_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == PATH_PARK && !park) |=> (idx_q == '0 && cnt_q == $past(latch_q))); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (st_q == PATH_RUN) |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + IDX_W'(1))); // R7
    AST_WTHRU_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (st_q == PATH_RUN && tmr_wr && wthru) |=> cnt_q == $past(wr_val)); // R8
    AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == PATH_RUN && tmr_wr && !wthru && !tick) |=> cnt_q == $past(cnt_q)); // R8

endmodule

// File: rtl/dtmf_out_stage.sv
module dtmf_out_stage
    import dtmf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic              tone_mode,
    input  logic [DATA_W-1:0] data_q,
    input  logic [SMP_W-1:0]  lo_smp,
    input  logic [SMP_W-1:0]  hi_smp,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_valid
);

    localparam int LOW_W = DATA_W - SUM_W;

    out_state_e        st_q;
    out_state_e        st_d;
    logic [SUM_W-1:0]  tone_sum;

    assign tone_sum = {1'b0, lo_smp} + {1'b0, hi_smp};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OUT_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_OFF: begin
                if (out_en) st_d = tone_mode ? OUT_TONE : OUT_PLAIN;
            end
            OUT_PLAIN: begin
                if (!out_en)       st_d = OUT_OFF;
                else if (tone_mode) st_d = OUT_TONE;
            end
            OUT_TONE: begin
                if (!out_en)        st_d = OUT_OFF;
                else if (!tone_mode) st_d = OUT_PLAIN;
            end
            default: st_d = OUT_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            OUT_PLAIN: begin
                dac_code  = data_q;
                dac_valid = 1'b1;
            end
            OUT_TONE: begin
                dac_code  = {tone_sum, data_q[LOW_W-1:0]};
                dac_valid = 1'b1;
            end
            default: begin
                dac_code  = '0;
                dac_valid = 1'b0;
            end
        endcase
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !out_en |=> (dac_code == '0 && !dac_valid)); // R2
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n) (out_en && !tone_mode) |=> (dac_code == data_q && dac_valid)); // R3
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n) (out_en && tone_mode) |=> (dac_code[LOW_W-1:0] == data_q[LOW_W-1:0] && dac_valid)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (st_q == OUT_TONE) |-> dac_code[DATA_W-1:LOW_W] <= SUM_W'(MAX_SUM)); // R9

endmodule

// File: rtl/dtmf_sample_gen.sv
module dtmf_sample_gen
    import dtmf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_valid
);

    ctl_t                ctl_q;
    logic [DATA_W-1:0]   data_q;
    logic [N_GROUPS-1:0] tmr_wr;
    logic [N_GROUPS-1:0] park_v;
    logic [N_GROUPS-1:0] wthru_v;
    logic [SMP_W-1:0]    smp [N_GROUPS];

    assign park_v  = {ctl_q.hi_zero,  ctl_q.lo_zero};
    assign wthru_v = {ctl_q.hi_wthru, ctl_q.lo_wthru};

    dtmf_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .data_q  (data_q),
        .tmr_wr  (tmr_wr)
    );

    // Group 0 is the low group, group 1 the high group
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_path
        dtmf_tone_path #(
            .TMR_W (TMR_W)
        ) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .park   (park_v[g]),
            .tmr_wr (tmr_wr[g]),
            .wthru  (wthru_v[g]),
            .wr_val (wr_data[TMR_W-1:0]),
            .sample (smp[g])
        );
    end

    dtmf_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (ctl_q.out_en),
        .tone_mode (ctl_q.tone_mode),
        .data_q    (data_q),
        .lo_smp    (smp[0]),
        .hi_smp    (smp[1]),
        .dac_code  (dac_code),
        .dac_valid (dac_valid)
    );

endmodule

// File: tb/dtmf_sample_gen_test.sv
`timescale 1ns/1ps
module dtmf_sample_gen_test;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_DAT = 2'd1;
    localparam logic [1:0] A_TLO = 2'd2;
    localparam logic [1:0] A_THI = 2'd3;
    localparam int SINE_REF [32] = '{16,19,21,24,26,28,30,31,31,31,30,28,26,24,21,19,
                                     15,12,10,7,5,3,1,0,0,0,1,3,5,7,10,12};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] dac_code;
    logic       dac_valid;

    int  edge_cnt = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    typedef struct {
        int         at;
        logic [7:0] code;
        logic       valid;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    dtmf_sample_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dac_code  (dac_code),
        .dac_valid (dac_valid)
    );

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    function automatic logic [7:0] tone_code(int lo, int hi, int low2);
        return 8'(((lo + hi) << 2) | low2);
    endfunction

    function automatic int sine_step(int n, int reload);
        return SINE_REF[((n - 1) / (2 * (reload + 1))) % 32];
    endfunction

    task automatic push(int at, logic [7:0] code, logic valid, string req);
        exp_t e;
        e.at = at; e.code = code; e.valid = valid; e.req = req;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare due items after each edge
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].at <= edge_cnt) begin
                e = sb.pop_front();
                checks++;
                if (e.at < edge_cnt) begin
                    errors++;
                    $display("FAIL %s: item for edge %0d missed (actual edge %0d, expected %0d)", e.req, e.at, edge_cnt, e.at);
                end else if (dac_code !== e.code || dac_valid !== e.valid) begin
                    errors++;
                    $display("FAIL %s: edge %0d actual code=%02h valid=%0b expected code=%02h valid=%0b",
                             e.req, edge_cnt, dac_code, dac_valid, e.code, e.valid);
                end
            end
        end
    end

    task automatic chk_now(string req, logic [7:0] code, logic valid);
        checks++;
        if (dac_code !== code || dac_valid !== valid) begin
            errors++;
            $display("FAIL %s: actual code=%02h valid=%0b expected code=%02h valid=%0b",
                     req, dac_code, dac_valid, code, valid);
        end
    endtask

    // Called just after a falling edge; the write lands on the next rising edge
    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still busy expected completion within 20000 cycles");
            finish_run();
        end
    end

    initial begin : driver
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_now("R1", 8'h00, 1'b0);
        idle(2);
        chk_now("R1", 8'h00, 1'b0);

        // R1: data register resets to 0, seen through plain mode
        w = edge_cnt + 1;
        push(w + 1, 8'h00, 1'b1, "R1");
        wr(A_CTL, 8'h0D);
        drain();

        // R2: disabled output stays zero whatever the data
        w = edge_cnt + 1;
        push(w + 1, 8'h00, 1'b0, "R2");
        push(w + 2, 8'h00, 1'b0, "R2");
        push(w + 4, 8'h00, 1'b0, "R2");
        wr(A_CTL, 8'h0C);
        wr(A_DAT, 8'hA5);
        drain();

        // R3: plain mode passes the full byte
        w = edge_cnt + 1;
        push(w + 1, 8'hA5, 1'b1, "R3");
        wr(A_CTL, 8'h0D);
        idle(2);
        w = edge_cnt + 1;
        push(w, 8'h3C, 1'b1, "R3");
        wr(A_DAT, 8'h3C);
        drain();

        // R4/R5: tone mode, both groups forced to zero, low bits from data
        wr(A_DAT, 8'h3E);
        w = edge_cnt + 1;
        push(w + 1, 8'h02, 1'b1, "R5");
        wr(A_CTL, 8'h0F);
        idle(2);
        w = edge_cnt + 1;
        push(w, 8'h01, 1'b1, "R4");
        wr(A_DAT, 8'hFD);
        idle(2);
        wr(A_DAT, 8'h3E);
        drain();

        // R6/R7: high group alone, reload 1, across a table wrap
        wr(A_THI, 8'd1);
        w = edge_cnt + 1;
        for (int n = 1; n <= 140; n++) begin
            push(w + n, tone_code(0, sine_step(n, 1), 2), 1'b1, (n > 128) ? "R7" : "R6");
        end
        wr(A_CTL, 8'h07);
        drain();

        // R5: forcing zero again silences the group
        w = edge_cnt + 1;
        push(w + 1, 8'h02, 1'b1, "R5");
        push(w + 3, 8'h02, 1'b1, "R5");
        wr(A_CTL, 8'h0F);
        drain();

        // R9/R7: both groups, reloads 2 and 4, released on the same edge
        wr(A_TLO, 8'd2);
        wr(A_THI, 8'd4);
        w = edge_cnt + 1;
        for (int n = 1; n <= 300; n++) begin
            push(w + n, tone_code(sine_step(n, 2), sine_step(n, 4), 2), 1'b1, "R9");
        end
        wr(A_CTL, 8'h03);
        drain();
        wr(A_CTL, 8'h0F);

        // R8: reload-only write while running
        wr(A_THI, 8'd1);
        w = edge_cnt + 1;
        for (int n = 1; n <= 90; n++) begin
            int s;
            s = (n <= 4) ? 16 : ((n <= 86) ? 19 : 21);
            push(w + n, tone_code(0, s, 2), 1'b1, "R8");
        end
        wr(A_CTL, 8'h07);
        idle(3);
        wr(A_THI, 8'd40);
        drain();
        wr(A_CTL, 8'h0F);

        // R8: write-through write while running
        wr(A_THI, 8'd1);
        w = edge_cnt + 1;
        for (int n = 1; n <= 170; n++) begin
            int s;
            s = (n <= 84) ? 16 : ((n <= 166) ? 19 : 21);
            push(w + n, tone_code(0, s, 2), 1'b1, "R8");
        end
        wr(A_CTL, 8'h27);
        idle(3);
        wr(A_THI, 8'd40);
        drain();

        // R3: plain mode while the tone keeps running
        w = edge_cnt + 1;
        push(w + 1, 8'h3E, 1'b1, "R3");
        push(w + 5, 8'h3E, 1'b1, "R3");
        wr(A_CTL, 8'h25);
        drain();

        done = 1;
        finish_run();
    end

endmodule